// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus-facing register set of a simple serial port. A bus master reaches eight word-aligned 32-bit registers through a slave port with separate read and write strobes. The block keeps one received byte in a holding register and passes each byte written to the data register on to a transmit engine. It keeps line and modem status bits. From those and an enable mask it drives one level interrupt, and a priority encoder picks the code that the identification register reports.

A receive engine presents bytes on `rxByte` with a one-cycle `rxValid` strobe. It should wait for `rxReady`, but a byte offered while the holding register is still full is accepted and flagged as an overrun. The transmit side gets `txByte` with a one-cycle `txStrobe`. The stored configuration (line format, modem control, divisor) is driven out to the serial engine. None of it can be read back over the bus. Bit timing, FIFOs and physical modem pins belong to other blocks, and `modemIn` is the already-conditioned modem status byte.

Top module: `mmio_uart_regs`

## Requirements
- R1: After reset, line status reads 0x60 (bit5 holding empty, bit6 transmitter empty), identification reads 0x1, `irq` is low, `rxReady` is high and all writable registers are zero.
- R2: A byte taken on `rxValid` is held and sets data ready (line status bit0), so `rxReady` drops in the next cycle. A read of the data register (byte address 0x00) returns the held byte in its low 8 bits and clears data ready.
- R3: A byte that arrives while data ready is set, without a same-cycle data read, sets overrun (line status bit1), replaces the held byte and leaves data ready set. Overrun stays set until reset.
- R4: Identification (address 0x08, bits 2:0) reports the highest enabled cause, in this order: overrun or another line error with enable bit2 gives 0b110, data ready with enable bit0 gives 0b100, holding empty with enable bit1 gives 0b010, any of modem status bits 3:0 with enable bit3 gives 0b000.
- R5: `irq` is high exactly when some enabled cause exists. With none, identification reads 0b001. The interrupt enable register sits at address 0x04 and uses bits 3:0.
- R6: A write to the data register puts bits 7:0 of the write data on `txByte` and pulses `txStrobe` high for one cycle, in the cycle after the write.
- R7: Line control (0x0C), modem control (0x10) and divisor (0x1C) are write-only, and their contents appear on `cfgLine`, `cfgModem` and `cfgDivisor`. Reads of these, of the enable register, of any unaligned address and of any address at 0x20 or above return zero.
- R8: A write to identification, line status (0x14), modem status (0x18), an unaligned address or an address at 0x20 or above changes nothing and raises `accessErr` for one cycle after the write.
- R9: If a data-register read and a byte arrival fall in the same cycle, the read returns the old byte, the new byte is held, data ready stays set and no overrun is recorded.
- R10: Modem status (0x18) reads the value of `modemIn` registered one cycle earlier.
- R11: Read data appears on `busRdata` in the cycle after `busRd` and is zero in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 6 | Byte address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| rxByte | input | 8 | Received byte |
| rxValid | input | 1 | Received byte strobe |
| rxReady | output | 1 | High while the holding register is empty |
| modemIn | input | 8 | Conditioned modem status byte |
| txByte | output | 8 | Byte to transmit |
| txStrobe | output | 1 | One-cycle transmit request |
| cfgLine | output | 8 | Stored line format |
| cfgModem | output | 8 | Stored modem control |
| cfgDivisor | output | 32 | Stored divisor |
| irq | output | 1 | Level interrupt |
| accessErr | output | 1 | One-cycle pulse for an illegal write |

## Verification
The collision that matters is a data-register read in the same cycle as a byte arrival. The bench provokes it by raising `busRd` at address 0x00 and `rxValid` on one clock edge while a byte is already held. It then checks that the read returned the old byte, that a later data read returns the new one, and that line status shows data ready without overrun. The contrasting case, an arrival with no read in that cycle, must set overrun, and the bench checks that this bit outranks data ready in the identification code.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  localparam int DATA_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int IER_W    = 4;
  localparam int LSR_W    = 7;
  localparam int MSR_W    = 8;
  localparam int ID_W     = 3;
  localparam int SEL_W    = $clog2(NUM_REGS);

  // register indices; byte address is index * 4
  localparam int IDX_DATA  = 0;
  localparam int IDX_IEN   = 1;
  localparam int IDX_IDENT = 2;
  localparam int IDX_LINE  = 3;
  localparam int IDX_MODEM = 4;
  localparam int IDX_LSTAT = 5;
  localparam int IDX_MSTAT = 6;
  localparam int IDX_DIV   = 7;

  // identification codes, highest priority first
  localparam logic [ID_W-1:0] ID_LINE  = 3'b110;
  localparam logic [ID_W-1:0] ID_RX    = 3'b100;
  localparam logic [ID_W-1:0] ID_TX    = 3'b010;
  localparam logic [ID_W-1:0] ID_MODEM = 3'b000;
  localparam logic [ID_W-1:0] ID_NONE  = 3'b001;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_DATA,
    SEL_IDENT,
    SEL_LSTAT,
    SEL_MSTAT
  } readSel_t;

  typedef struct packed {
    logic     rdValid;
    readSel_t rdSel;
    logic     rdData;
    logic     wrData;
    logic     wrIen;
    logic     wrLine;
    logic     wrModem;
    logic     wrDiv;
    logic     badWr;
  } regStrobes_t;

endpackage

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output regStrobes_t       strobes
);

  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic             mapped;
  logic [IDX_W-1:0] wordIdx;
  logic [SEL_W-1:0] regSel;

  always_comb begin
    aligned = (busAddr[1:0] == 2'b00);
    wordIdx = busAddr[ADDR_W-1:2];
    mapped  = aligned && (int'(wordIdx) < NUM_REGS);
    regSel  = wordIdx[SEL_W-1:0];
  end

  // read decode
  always_comb begin
    strobes.rdValid = busRd;
    strobes.rdData  = 1'b0;
    strobes.rdSel   = SEL_ZERO;
    if (busRd && mapped) begin
      case (regSel)
        SEL_W'(IDX_DATA): begin
          strobes.rdSel  = SEL_DATA;
          strobes.rdData = 1'b1;
        end
        SEL_W'(IDX_IDENT): strobes.rdSel = SEL_IDENT;
        SEL_W'(IDX_LSTAT): strobes.rdSel = SEL_LSTAT;
        SEL_W'(IDX_MSTAT): strobes.rdSel = SEL_MSTAT;
        default:           strobes.rdSel = SEL_ZERO;
      endcase
    end
  end

  // write decode
  always_comb begin
    strobes.wrData  = 1'b0;
    strobes.wrIen   = 1'b0;
    strobes.wrLine  = 1'b0;
    strobes.wrModem = 1'b0;
    strobes.wrDiv   = 1'b0;
    strobes.badWr   = 1'b0;
    if (busWr) begin
      if (!mapped) begin
        strobes.badWr = 1'b1;
      end else begin
        case (regSel)
          SEL_W'(IDX_DATA):  strobes.wrData  = 1'b1;
          SEL_W'(IDX_IEN):   strobes.wrIen   = 1'b1;
          SEL_W'(IDX_LINE):  strobes.wrLine  = 1'b1;
          SEL_W'(IDX_MODEM): strobes.wrModem = 1'b1;
          SEL_W'(IDX_DIV):   strobes.wrDiv   = 1'b1;
          default:           strobes.badWr   = 1'b1;
        endcase
      end
    end
  end

  // at most one write target per access (R8)
  assert_wr_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrData, strobes.wrIen, strobes.wrLine,
              strobes.wrModem, strobes.wrDiv, strobes.badWr}));

endmodule

// File: rtl/uart_regs_prio.sv
module uart_regs_prio
  import uart_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IER_W-1:0] ienQ,
  input  logic [LSR_W-1:0] lstat,
  input  logic [MSR_W-1:0] mstat,
  output logic             irqOut,
  output logic [ID_W-1:0]  idCode
);

  logic lineCause;
  logic rxCause;
  logic txCause;
  logic modemCause;

  always_comb begin
    lineCause  = (|lstat[4:1]) && ienQ[2];
    rxCause    = lstat[0] && ienQ[0];
    txCause    = lstat[5] && ienQ[1];
    modemCause = (|mstat[3:0]) && ienQ[3];
  end

  always_comb begin
    irqOut = 1'b1;
    if (lineCause)       idCode = ID_LINE;
    else if (rxCause)    idCode = ID_RX;
    else if (txCause)    idCode = ID_TX;
    else if (modemCause) idCode = ID_MODEM;
    else begin
      idCode = ID_NONE;
      irqOut = 1'b0;
    end
  end

  // no enable bit set means no interrupt (R5)
  assert_no_enable_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ienQ == '0) |-> !irqOut);

  // a low interrupt pairs with the idle code (R5)
  assert_idle_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (idCode == ID_NONE));

  // a line error outranks every other cause (R4)
  assert_line_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lstat[1] && ienQ[2]) |-> (idCode == ID_LINE));

endmodule

// File: rtl/uart_regs_dpath.sv
module uart_regs_dpath
  import uart_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxValid,
  input  logic [MSR_W-1:0]  modemIn,
  input  logic [ID_W-1:0]   idCode,
  output logic [DATA_W-1:0] busRdata,
  output logic              rxReady,
  output logic [BYTE_W-1:0] txByte,
  output logic              txStrobe,
  output logic              accessErr,
  output logic [BYTE_W-1:0] cfgLine,
  output logic [BYTE_W-1:0] cfgModem,
  output logic [DATA_W-1:0] cfgDivisor,
  output logic [IER_W-1:0]  ienQ,
  output logic [LSR_W-1:0]  lstat,
  output logic [MSR_W-1:0]  mstat
);

  logic [BYTE_W-1:0] holdByte;
  logic              dataReady;
  logic              overrun;
  logic              txIdle;
  logic [DATA_W-1:0] readMux;

  // line status: bit6 tx empty, bit5 holding empty, bits4:2 unused errors,
  // bit1 overrun, bit0 data ready
  always_comb begin
    lstat   = {txIdle, txIdle, 3'b000, overrun, dataReady};
    rxReady = !dataReady;
  end

  // receive holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte  <= '0;
      dataReady <= 1'b0;
      overrun   <= 1'b0;
    end else if (rxValid) begin
      holdByte  <= rxByte;
      dataReady <= 1'b1;
      if (dataReady && !strobes.rdData) overrun <= 1'b1;
    end else if (strobes.rdData) begin
      dataReady <= 1'b0;
    end
  end

  // no serial engine is modelled here, so the transmitter always reports idle
  always_ff @(posedge clk) begin
    if (!rstN) txIdle <= 1'b1;
    else       txIdle <= txIdle;
  end

  // write-only configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienQ       <= '0;
      cfgLine    <= '0;
      cfgModem   <= '0;
      cfgDivisor <= '0;
    end else begin
      if (strobes.wrIen)   ienQ       <= busWdata[IER_W-1:0];
      if (strobes.wrLine)  cfgLine    <= busWdata[BYTE_W-1:0];
      if (strobes.wrModem) cfgModem   <= busWdata[BYTE_W-1:0];
      if (strobes.wrDiv)   cfgDivisor <= busWdata;
    end
  end

  // modem status sample
  always_ff @(posedge clk) begin
    if (!rstN) mstat <= '0;
    else       mstat <= modemIn;
  end

  // transmit hand-off and error pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txByte    <= '0;
      txStrobe  <= 1'b0;
      accessErr <= 1'b0;
    end else begin
      txStrobe  <= strobes.wrData;
      accessErr <= strobes.badWr;
      if (strobes.wrData) txByte <= busWdata[BYTE_W-1:0];
    end
  end

  // read path
  always_comb begin
    unique case (strobes.rdSel)
      SEL_DATA:  readMux = DATA_W'(holdByte);
      SEL_IDENT: readMux = DATA_W'(idCode);
      SEL_LSTAT: readMux = DATA_W'(lstat);
      SEL_MSTAT: readMux = DATA_W'(mstat);
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                busRdata <= '0;
    else if (strobes.rdValid) busRdata <= readMux;
    else                      busRdata <= '0;
  end

  assert_arrival_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxReady);

  assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !strobes.rdData) |=> lstat[1]);

  assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    lstat[1] |=> lstat[1]);

  assert_collide_clean_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && strobes.rdData && !lstat[1]) |=> (!lstat[1] && !rxReady));

  assert_tx_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrData |=> txStrobe);

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.badWr |=> accessErr);

  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdValid |=> (busRdata == '0));

endmodule

// File: rtl/mmio_uart_regs.sv
module mmio_uart_regs
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [MSR_W-1:0]  modemIn,
  output logic [BYTE_W-1:0] txByte,
  output logic              txStrobe,
  output logic [BYTE_W-1:0] cfgLine,
  output logic [BYTE_W-1:0] cfgModem,
  output logic [DATA_W-1:0] cfgDivisor,
  output logic              irq,
  output logic              accessErr
);

  regStrobes_t      strobes;
  logic [IER_W-1:0] ienQ;
  logic [LSR_W-1:0] lstat;
  logic [MSR_W-1:0] mstat;
  logic [ID_W-1:0]  idCode;

  uart_regs_ctrl #(.ADDR_W(ADDR_W)) ctrlInst (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strobes (strobes)
  );

  uart_regs_dpath dpathInst (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busWdata   (busWdata),
    .rxByte     (rxByte),
    .rxValid    (rxValid),
    .modemIn    (modemIn),
    .idCode     (idCode),
    .busRdata   (busRdata),
    .rxReady    (rxReady),
    .txByte     (txByte),
    .txStrobe   (txStrobe),
    .accessErr  (accessErr),
    .cfgLine    (cfgLine),
    .cfgModem   (cfgModem),
    .cfgDivisor (cfgDivisor),
    .ienQ       (ienQ),
    .lstat      (lstat),
    .mstat      (mstat)
  );

  uart_regs_prio prioInst (
    .clk    (clk),
    .rstN   (rstN),
    .ienQ   (ienQ),
    .lstat  (lstat),
    .mstat  (mstat),
    .irqOut (irq),
    .idCode (idCode)
  );

endmodule

// File: tb/mmio_uart_regs_test.sv
module mmio_uart_regs_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  rxByte = '0;
  logic        rxValid = 1'b0;
  logic        rxReady;
  logic [7:0]  modemIn = '0;
  logic [7:0]  txByte;
  logic        txStrobe;
  logic [7:0]  cfgLine;
  logic [7:0]  cfgModem;
  logic [31:0] cfgDivisor;
  logic        irq;
  logic        accessErr;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  mmio_uart_regs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .rxByte(rxByte), .rxValid(rxValid),
    .rxReady(rxReady), .modemIn(modemIn), .txByte(txByte), .txStrobe(txStrobe),
    .cfgLine(cfgLine), .cfgModem(cfgModem), .cfgDivisor(cfgDivisor),
    .irq(irq), .accessErr(accessErr)
  );

  typedef struct packed {
    logic       wr;
    logic [5:0] addr;
    logic [7:0] wdat;
    logic [7:0] expRd;
    logic       expIrq;
    logic       expErr;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 6'h14, 8'h00, 8'h60, 1'b0, 1'b0},
    '{1'b0, 6'h08, 8'h00, 8'h01, 1'b0, 1'b0},
    '{1'b1, 6'h04, 8'h02, 8'h00, 1'b1, 1'b0},
    '{1'b0, 6'h08, 8'h00, 8'h02, 1'b1, 1'b0},
    '{1'b0, 6'h04, 8'h00, 8'h00, 1'b1, 1'b0},
    '{1'b1, 6'h04, 8'h00, 8'h00, 1'b0, 1'b0},
    '{1'b0, 6'h1C, 8'h00, 8'h00, 1'b0, 1'b0},
    '{1'b0, 6'h20, 8'h00, 8'h00, 1'b0, 1'b0},
    '{1'b1, 6'h14, 8'h00, 8'h00, 1'b0, 1'b1},
    '{1'b0, 6'h14, 8'h00, 8'h60, 1'b0, 1'b0},
    '{1'b1, 6'h21, 8'h02, 8'h00, 1'b0, 1'b1},
    '{1'b0, 6'h18, 8'h00, 8'h00, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    rxByte = b; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    applyReset();

    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 rxReady", 32'(rxReady), 32'h1);
    check("R11 idle rdata", busRdata, 32'h0);
    check("R7 cfgDivisor reset", cfgDivisor, 32'h0);

    // table: R1 R4 R5 R7 R8 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].wr) begin
        busWrite(VEC[i].addr, {24'h0, VEC[i].wdat});
        check($sformatf("R8 table %0d accessErr", i), 32'(accessErr), 32'(VEC[i].expErr));
      end else begin
        busRead(VEC[i].addr, rd);
        check($sformatf("R7 table %0d rdata", i), rd, {24'h0, VEC[i].expRd});
      end
      check($sformatf("R5 table %0d irq", i), 32'(irq), 32'(VEC[i].expIrq));
    end

    // R8 error is a single-cycle pulse
    busWrite(6'h18, 32'hFF);
    @(negedge clk);
    check("R8 pulse ends", 32'(accessErr), 32'h0);

    // R2 receive and consume
    sendByte(8'hA5);
    check("R2 rxReady low", 32'(rxReady), 32'h0);
    busRead(6'h14, rd);
    check("R2 lstat ready", rd, 32'h61);
    busWrite(6'h04, 32'h1);
    check("R5 rx irq", 32'(irq), 32'h1);
    busRead(6'h08, rd);
    check("R4 rx code", rd, 32'h4);
    busRead(6'h00, rd);
    check("R2 data", rd, 32'hA5);
    check("R2 rxReady back", 32'(rxReady), 32'h1);
    check("R5 irq cleared", 32'(irq), 32'h0);
    busRead(6'h14, rd);
    check("R2 lstat cleared", rd, 32'h60);

    // R9 read and arrival in the same cycle
    sendByte(8'h33);
    @(negedge clk);
    busAddr = 6'h00; busRd = 1'b1; rxByte = 8'h44; rxValid = 1'b1;
    @(negedge clk);
    busRd = 1'b0; rxValid = 1'b0;
    check("R9 old byte", busRdata, 32'h33);
    busRead(6'h14, rd);
    check("R9 no overrun", rd, 32'h61);
    busRead(6'h00, rd);
    check("R9 new byte", rd, 32'h44);

    // R3 overrun
    sendByte(8'h11);
    sendByte(8'h22);
    busRead(6'h14, rd);
    check("R3 overrun set", rd, 32'h63);
    busWrite(6'h04, 32'h5);
    busRead(6'h08, rd);
    check("R4 line over rx", rd, 32'h6);
    busRead(6'h00, rd);
    check("R3 newest byte", rd, 32'h22);
    busRead(6'h14, rd);
    check("R3 overrun sticky", rd, 32'h62);
    check("R3 irq held", 32'(irq), 32'h1);
    applyReset();
    busRead(6'h14, rd);
    check("R1 overrun cleared", rd, 32'h60);
    check("R1 irq after reset", 32'(irq), 32'h0);

    // R4 R10 modem cause and ordering
    modemIn = 8'h01;
    busWrite(6'h04, 32'h8);
    check("R5 modem irq", 32'(irq), 32'h1);
    busRead(6'h08, rd);
    check("R4 modem code", rd, 32'h0);
    busRead(6'h18, rd);
    check("R10 modem read", rd, 32'h01);
    busWrite(6'h04, 32'hA);
    busRead(6'h08, rd);
    check("R4 tx over modem", rd, 32'h2);
    busWrite(6'h04, 32'hB);
    sendByte(8'h55);
    busRead(6'h08, rd);
    check("R4 rx over tx", rd, 32'h4);
    busRead(6'h00, rd);
    modemIn = 8'h10;
    busWrite(6'h04, 32'h8);
    check("R5 upper modem bits ignored", 32'(irq), 32'h0);
    busRead(6'h18, rd);
    check("R10 modem upper", rd, 32'h10);

    // R6 transmit
    busWrite(6'h00, 32'h1C5);
    check("R6 strobe", 32'(txStrobe), 32'h1);
    check("R6 byte", 32'(txByte), 32'hC5);
    @(negedge clk);
    check("R6 strobe one cycle", 32'(txStrobe), 32'h0);

    // R7 configuration outputs, not readable
    busWrite(6'h0C, 32'h1B);
    busWrite(6'h10, 32'h03);
    busWrite(6'h1C, 32'h0001_2345);
    check("R7 cfgLine", 32'(cfgLine), 32'h1B);
    check("R7 cfgModem", 32'(cfgModem), 32'h03);
    check("R7 cfgDivisor", cfgDivisor, 32'h0001_2345);
    busRead(6'h0C, rd);
    check("R7 line unreadable", rd, 32'h0);

    // R8 illegal write leaves identification intact
    busWrite(6'h08, 32'h7);
    check("R8 ident write err", 32'(accessErr), 32'h1);
    busRead(6'h08, rd);
    check("R8 ident unchanged", rd, 32'h1);

    finishRun();
  end

endmodule